// File: doc/BRIEF.md
# Successive-Approximation ADC Register Front End and Sequencer

This block holds the byte-wide control register, the result register and the interrupt request of an 8-bit successive-approximation converter in a small microcontroller. It decodes the channel field, starts single or back-to-back conversions through a start/halt handshake to the converter datapath, captures each result, and keeps a completion flag. The flag and the interrupt clear as a side effect of bus traffic: a write to the control register or a read of the result register.

A low-power stop input freezes the sequencer. A conversion that stop cuts short is restarted when stop is released. The first result after the restart is thrown away because the analog circuitry has not yet settled, and a second conversion follows on its own. The analog path and the clock divider live elsewhere.

Top module: `adcSeqTop`

## Requirements
- R1: After reset the control register reads 0x1F, the result register reads 0x00, irqReq is low and convStart is low.
- R2: Control byte layout: bit 7 completion flag (read-only, the written value has no effect), bit 6 interrupt enable, bit 5 continuous mode, bits 4:0 channel. Bits 6:0 read back as written.
- R3: A control write with channel 0..12 pulses convStart in the write cycle, with convChan equal to the channel. Channels 13..31 start nothing, and 31 also holds convHalt high.
- R4: With interrupts disabled, each accepted completion copies convResult into the result register and sets bit 7 of the control byte.
- R5: With interrupts enabled, bit 7 always reads 0, and each accepted completion raises irqReq.
- R6: A result-register read (dataRdEn) or any control write clears both the flag and irqReq on the next cycle.
- R7: When a result read coincides with an accepted completion, the new result and the flag or interrupt win over the clear.
- R8: A valid control write during a conversion aborts it. The completion that the old conversion would have produced is never captured, and only the new conversion's result is stored.
- R9: In continuous mode each completion starts the next conversion in the same cycle and overwrites the result register.
- R10: While stopReq is high, convStart stays low, convHalt is high and no completion is captured.
- R11: When stop is released after it aborted a conversion, a conversion restarts at once. Its result is discarded, a second conversion starts by itself, and only that second result is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 8 | Control write byte |
| ctrlRdData | output | 8 | Control register read value |
| dataRdEn | input | 1 | Result register read strobe (clears flag/irq) |
| dataRdData | output | 8 | Result register |
| irqReq | output | 1 | Interrupt request |
| stopReq | input | 1 | Low-power stop |
| convStart | output | 1 | Start (or restart) a conversion |
| convHalt | output | 1 | Converter idle/abort level |
| convChan | output | 4 | Channel to sample |
| convDone | input | 1 | Converter finished, result valid |
| convResult | input | 8 | Converter result |

## Verification
The bench aims at the cycle where a result read meets a completion. A design that lets the clear win there loses the flag and the result. A restart in mid-conversion is checked at the moment the aborted conversion would have finished: a design that still accepts that stale completion shows the flag early.

Stop is held across a conversion, and the bench checks that no start appears and no result is taken during stop. After stop is released, the settling result must be dropped. A design without the discard stores it one period too early. Reserved and power-down channels must start nothing, and a write to the read-only flag bit must not set it.

// File: rtl/adcSeqPkg.sv
package adcSeqPkg;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_RUN     = 2'd1,
    SEQ_SETTLE  = 2'd2,
    SEQ_STOPPED = 2'd3
  } seqState_t;

  typedef struct packed {
    logic startConv;
    logic latchResult;
    logic clearFlag;
  } seqStrobes_t;

endpackage

// File: rtl/adcSeqCtrl.sv
module adcSeqCtrl
  import adcSeqPkg::*;
#(
  parameter int NUM_CH = 13,
  parameter int CH_W   = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ctrlWrEn,
  input  logic [CH_W-1:0] wrChan,
  input  logic            dataRdEn,
  input  logic [CH_W-1:0] curChan,
  input  logic            curCont,
  input  logic            stopReq,
  input  logic            convDone,
  output seqStrobes_t     strobes,
  output logic            convHalt
);

  localparam logic [CH_W-1:0] CH_LIMIT = CH_W'(NUM_CH);

  seqState_t state, nextState;
  logic      resume, nextResume;
  logic      wrOk, curOk;

  assign wrOk  = wrChan < CH_LIMIT;
  assign curOk = curChan < CH_LIMIT;

  always_comb begin
    nextState           = state;
    nextResume          = resume;
    strobes.startConv   = 1'b0;
    strobes.latchResult = 1'b0;
    strobes.clearFlag   = ctrlWrEn | dataRdEn;
    if (stopReq) begin
      nextState = SEQ_STOPPED;
      if (state == SEQ_RUN || state == SEQ_SETTLE) nextResume = 1'b1;
      if (ctrlWrEn) nextResume = wrOk;
    end else if (ctrlWrEn) begin
      nextResume        = 1'b0;
      strobes.startConv = wrOk;
      nextState         = wrOk ? SEQ_RUN : SEQ_IDLE;
    end else if (state == SEQ_STOPPED) begin
      nextResume = 1'b0;
      if (resume && curOk) begin
        strobes.startConv = 1'b1;
        nextState         = SEQ_SETTLE;
      end else begin
        nextState = SEQ_IDLE;
      end
    end else if (convDone && state == SEQ_RUN) begin
      strobes.latchResult = 1'b1;
      if (curCont && curOk) strobes.startConv = 1'b1;
      else nextState = SEQ_IDLE;
    end else if (convDone && state == SEQ_SETTLE) begin
      strobes.startConv = 1'b1;
      nextState         = SEQ_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= SEQ_IDLE;
      resume <= 1'b0;
    end else begin
      state  <= nextState;
      resume <= nextResume;
    end
  end

  assign convHalt = stopReq || state == SEQ_IDLE || state == SEQ_STOPPED;

  assert_stop_no_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |-> !strobes.startConv);
  assert_stop_no_latch_R10: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |-> !strobes.latchResult);
  assert_reserved_no_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && wrChan >= CH_LIMIT) |-> !strobes.startConv);
  assert_settle_discard_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_SETTLE && convDone && !stopReq && !ctrlWrEn) |-> !strobes.latchResult);

endmodule

// File: rtl/adcSeqDatapath.sv
module adcSeqDatapath
  import adcSeqPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CH_W   = 5,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic              ctrlWrEn,
  input  logic [7:0]        ctrlWrData,
  input  logic [DATA_W-1:0] convResult,
  output logic [7:0]        ctrlRdData,
  output logic [DATA_W-1:0] dataRdData,
  output logic              irqReq,
  output logic [CH_W-1:0]   curChan,
  output logic              curCont,
  output logic [SEL_W-1:0]  convChan
);

  logic              intEn, doneFlag;
  logic [DATA_W-1:0] dataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEn   <= 1'b0;
      curCont <= 1'b0;
      curChan <= '1;
    end else if (ctrlWrEn) begin
      intEn   <= ctrlWrData[6];
      curCont <= ctrlWrData[5];
      curChan <= ctrlWrData[CH_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg  <= '0;
      doneFlag <= 1'b0;
    end else if (strobes.latchResult) begin
      dataReg  <= convResult;
      doneFlag <= 1'b1;
    end else if (strobes.clearFlag) begin
      doneFlag <= 1'b0;
    end
  end

  assign ctrlRdData = {doneFlag & ~intEn, intEn, curCont, curChan};
  assign dataRdData = dataReg;
  assign irqReq     = doneFlag & intEn;
  assign convChan   = ctrlWrEn ? ctrlWrData[SEL_W-1:0] : curChan[SEL_W-1:0];

  assert_flag_masked_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdData[6] |-> !ctrlRdData[7]);
  assert_latch_value_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchResult |=> dataRdData == $past(convResult));
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clearFlag && !strobes.latchResult) |=> (!irqReq && !ctrlRdData[7]));
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchResult |=> (irqReq || ctrlRdData[7]));
  assert_flag_readonly_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && ctrlWrData[7]) |=> !ctrlRdData[7]);

endmodule

// File: rtl/adcSeqTop.sv
module adcSeqTop
  import adcSeqPkg::*;
#(
  parameter int NUM_CH = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [7:0]        ctrlWrData,
  output logic [7:0]        ctrlRdData,
  input  logic              dataRdEn,
  output logic [DATA_W-1:0] dataRdData,
  output logic              irqReq,
  input  logic              stopReq,
  output logic              convStart,
  output logic              convHalt,
  output logic [3:0]        convChan,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convResult
);

  localparam int CH_W  = 5;
  localparam int SEL_W = 4;

  seqStrobes_t     strobes;
  logic [CH_W-1:0] curChan;
  logic            curCont;

  adcSeqCtrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .wrChan(ctrlWrData[CH_W-1:0]),
    .dataRdEn(dataRdEn), .curChan(curChan), .curCont(curCont), .stopReq(stopReq),
    .convDone(convDone), .strobes(strobes), .convHalt(convHalt)
  );

  adcSeqDatapath #(.DATA_W(DATA_W), .CH_W(CH_W), .SEL_W(SEL_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ctrlWrEn(ctrlWrEn),
    .ctrlWrData(ctrlWrData), .convResult(convResult), .ctrlRdData(ctrlRdData),
    .dataRdData(dataRdData), .irqReq(irqReq), .curChan(curChan),
    .curCont(curCont), .convChan(convChan)
  );

  assign convStart = strobes.startConv;

endmodule

// File: tb/test_adcSeqTop.sv
module test_adcSeqTop;

  localparam int PERIOD = 10;
  localparam int CONV   = 8;

  typedef struct packed {
    logic [7:0] wr;
  } vec_t;
  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'h00}, '{8'h0C}, '{8'h47}, '{8'h0D}, '{8'h1F}, '{8'hC5}, '{8'h89}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWrEn = 1'b0;
  logic [7:0] ctrlWrData = 8'h00;
  logic       dataRdEn = 1'b0;
  logic       stopReq = 1'b0;
  logic       convDone;
  logic [7:0] convResult;
  logic [7:0] ctrlRdData, dataRdData;
  logic       irqReq, convStart, convHalt;
  logic [3:0] convChan;

  int nChecks = 0;
  int nFail   = 0;
  int startCnt = 0;
  int cnt = 0;
  logic [3:0] chanLat = 4'd0;

  always #(PERIOD/2) clk = ~clk;

  adcSeqTop i_adcSeqTop (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .ctrlRdData(ctrlRdData), .dataRdEn(dataRdEn), .dataRdData(dataRdData),
    .irqReq(irqReq), .stopReq(stopReq), .convStart(convStart),
    .convHalt(convHalt), .convChan(convChan), .convDone(convDone),
    .convResult(convResult)
  );

  function automatic logic [7:0] resOf(input logic [3:0] ch);
    return 8'(ch * 37 + 11);
  endfunction

  // Counter model of the converter datapath.
  always @(posedge clk) begin
    if (!rstN) cnt <= 0;
    else if (convStart) begin
      cnt <= CONV;
      chanLat <= convChan;
      startCnt <= startCnt + 1;
    end else if (convHalt) cnt <= 0;
    else if (cnt != 0) cnt <= cnt - 1;
  end
  assign convDone   = (cnt == 1);
  assign convResult = resOf(chanLat);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrCtrl(input logic [7:0] b);
    @(negedge clk);
    ctrlWrEn = 1'b1;
    ctrlWrData = b;
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  task automatic rdData();
    @(negedge clk);
    dataRdEn = 1'b1;
    @(negedge clk);
    dataRdEn = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [7:0] lastData;
    int s0;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    // R1 reset state
    chk("R1 ctrl", 32'(ctrlRdData), 32'h1F);
    chk("R1 data", 32'(dataRdData), 32'h00);
    chk("R1 irq", 32'(irqReq), 32'd0);
    chk("R1 start", 32'(convStart), 32'd0);
    lastData = 8'h00;

    // Vector walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      logic [7:0] w;
      logic starts;
      w = VECS[i].wr;
      starts = (w[4:0] < 5'd13);
      s0 = startCnt;
      wrCtrl(w);
      chk("R3 start count", 32'(startCnt - s0), 32'(starts));
      waitCyc(CONV + 2);
      if (starts) lastData = resOf(w[3:0]);
      chk("R2 R4 R5 ctrl read", 32'(ctrlRdData), 32'({starts & ~w[6], w[6:0]}));
      chk("R5 irq", 32'(irqReq), 32'(starts & w[6]));
      chk("R4 data", 32'(dataRdData), 32'(lastData));
      if (w[4:0] == 5'h1F) chk("R3 halt", 32'(convHalt), 32'd1);
      rdData();
      chk("R6 read clears", 32'({ctrlRdData[7], irqReq}), 32'd0);
    end

    // R6: control write clears irq
    wrCtrl(8'h48);
    waitCyc(CONV + 2);
    chk("R5 irq set", 32'(irqReq), 32'd1);
    wrCtrl(8'h5F);
    chk("R6 write clears irq", 32'(irqReq), 32'd0);
    chk("R2 readback", 32'(ctrlRdData), 32'h5F);

    // R8: abort and restart
    wrCtrl(8'h03);
    waitCyc(3);
    wrCtrl(8'h05);
    waitCyc(4);
    chk("R8 stale not captured flag", 32'(ctrlRdData[7]), 32'd0);
    chk("R8 stale not captured data", 32'(dataRdData), 32'(resOf(4'd8)));
    waitCyc(CONV);
    chk("R8 new result", 32'(dataRdData), 32'(resOf(4'd5)));
    chk("R8 flag", 32'(ctrlRdData[7]), 32'd1);
    rdData();

    // R9: continuous mode
    s0 = startCnt;
    wrCtrl(8'h23);
    waitCyc(CONV + 2);
    chk("R9 first", 32'({ctrlRdData[7], dataRdData}), 32'({1'b1, resOf(4'd3)}));
    rdData();
    chk("R9 cleared", 32'(ctrlRdData[7]), 32'd0);
    waitCyc(CONV);
    chk("R9 auto restart flag", 32'(ctrlRdData[7]), 32'd1);
    chk("R9 restarts", 32'(startCnt - s0 >= 3), 32'd1);
    wrCtrl(8'h1F);
    rdData();

    // R7: read collides with completion
    wrCtrl(8'h06);
    @(negedge clk);
    while (!convDone) @(negedge clk);
    dataRdEn = 1'b1;
    @(negedge clk);
    dataRdEn = 1'b0;
    chk("R7 set wins flag", 32'(ctrlRdData[7]), 32'd1);
    chk("R7 set wins data", 32'(dataRdData), 32'(resOf(4'd6)));
    rdData();

    // R10 / R11: stop aborts, resume discards the settling result
    wrCtrl(8'h02);
    waitCyc(3);
    s0 = startCnt;
    stopReq = 1'b1;
    waitCyc(20);
    chk("R10 no start in stop", 32'(startCnt - s0), 32'd0);
    chk("R10 no capture", 32'(ctrlRdData[7]), 32'd0);
    chk("R10 halt", 32'(convHalt), 32'd1);
    stopReq = 1'b0;
    waitCyc(CONV + 2);
    chk("R11 settle discarded", 32'(ctrlRdData[7]), 32'd0);
    chk("R11 data kept", 32'(dataRdData), 32'(resOf(4'd6)));
    waitCyc(CONV + 2);
    chk("R11 second captured", 32'({ctrlRdData[7], dataRdData}), 32'({1'b1, resOf(4'd2)}));
    chk("R11 two starts", 32'(startCnt - s0), 32'd2);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule